// File: doc/BRIEF.md
# Priority Preemptive Interrupt Controller

This block collects a set of level-sensitive interrupt requests, each with a 4-bit priority that software programs. It signals the processor when a pending request has a priority strictly above the current running priority. When the processor acknowledges, the controller returns that source's 9-bit vector and raises the running priority to the priority of the source it has just accepted. The previous running priority is saved on a LIFO, so a higher-priority request can still preempt the handler. Each end-of-interrupt restores the saved priority.

Software can also write the running priority directly. This lets a task raise a ceiling while it holds a resource that it shares with other handlers. Among requests of equal priority, the lowest source index wins. An acknowledge with no eligible source returns a reserved spurious vector. An acknowledge is also spurious when the save stack is already full.

The request line is driven by a two-state machine. ST_QUIET means no eligible source exists, and ST_SIGNAL means the request line is asserted. Transition T_RAISE goes from ST_QUIET to ST_SIGNAL when an eligible source is seen. Transition T_DROP goes from ST_SIGNAL to ST_QUIET when none remains. Each state holds itself (T_HOLD_Q, T_HOLD_S) otherwise.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_o is 0, cur_prio_o is 0, nest_depth_o is 0, and vec_o holds the spurious vector 0x1FF.
- R2: A source is eligible only when its req_i bit is 1 and its priority is strictly greater than cur_prio_o. A priority of 0 therefore never interrupts.
- R3: Among eligible sources, the one with the numerically highest priority wins. Ties go to the lowest source index.
- R4: On an acknowledge (ack_i high for one cycle) with a winner, vec_o shows the winner's index zero-extended to 9 bits, starting at the clock edge that samples ack_i.
- R5: irq_o rises at the first clock edge after an eligible source exists. It falls at the first clock edge after none remains.
- R6: An accepted acknowledge pushes cur_prio_o onto the save stack, increments nest_depth_o and sets cur_prio_o to the winner's priority.
- R7: eoi_i pops the save stack into cur_prio_o and decrements nest_depth_o. With an empty stack, eoi_i changes nothing. When ack_i and eoi_i are both high, only the eoi_i is acted on.
- R8: An acknowledge with no eligible source sets vec_o to 0x1FF and leaves cur_prio_o and nest_depth_o unchanged.
- R9: A configuration write with cfg_sel_i equal to NSRC (8 by default) loads cfg_data_i into cur_prio_o. A write with cfg_sel_i below NSRC sets that source's priority.
- R10: With the stack holding 16 entries, an acknowledge is spurious: vec_o becomes 0x1FF, and nest_depth_o stays 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NSRC | Level-sensitive interrupt requests |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | $clog2(NSRC+1) | Write target: source index, or NSRC for the running priority |
| cfg_data_i | input | PRIO_W | Priority value to write |
| ack_i | input | 1 | Acknowledge pulse from the processor |
| eoi_i | input | 1 | End-of-interrupt pulse |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | VEC_W | Vector captured at the last acknowledge |
| cur_prio_o | output | PRIO_W | Running priority |
| nest_depth_o | output | $clog2(DEPTH+1) | Number of saved priorities |

## Verification
The assertions assume that every input is known and changes only between clock edges. They also assume that cfg_sel_i never exceeds NSRC, and that a configuration write does not land in the same cycle as an acknowledge that they check for a stable running priority. The bench drives all inputs at the falling edge and issues one operation per cycle. It sweeps pseudo-random priority maps, request patterns and ceilings, and compares the results with a winner model derived from the priority and tie rules.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_SIGNAL = 1'b1
    } irq_state_e;
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 4,
    parameter int SEL_W  = $clog2(NSRC + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we_i,
    input  logic [SEL_W-1:0]               sel_i,
    input  logic [PRIO_W-1:0]              data_i,
    output logic [NSRC-1:0][PRIO_W-1:0]    prio_o
);
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                prio_o[g] <= '0;
            else if (we_i && (sel_i == SEL_W'(g)))
                prio_o[g] <= data_i;
        end

        // R9
        src_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we_i && sel_i == SEL_W'(g)) |=> prio_o[g] == $past(data_i));
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSRC-1:0]             req_i,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]           ceil_i,
    output logic                        any_o,
    output logic [IDX_W-1:0]            idx_o,
    output logic [PRIO_W-1:0]           prio_o
);
    always_comb begin
        any_o  = 1'b0;
        idx_o  = '0;
        prio_o = ceil_i;
        for (int i = 0; i < NSRC; i++) begin
            if (req_i[i] && (prio_i[i] > prio_o)) begin
                any_o  = 1'b1;
                idx_o  = IDX_W'(i);
                prio_o = prio_i[i];
            end
        end
    end

    // R2
    win_above_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> (req_i[idx_o] && prio_i[idx_o] > ceil_i));
    // R3
    win_matches_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> (prio_o == prio_i[idx_o]));
endmodule

// File: rtl/irq_prio_stack.sv
module irq_prio_stack #(
    parameter int DEPTH  = 16,
    parameter int W      = 4,
    parameter int DEP_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [W-1:0]     din_i,
    output logic [W-1:0]     top_o,
    output logic [DEP_W-1:0] depth_o,
    output logic             full_o,
    output logic             empty_o
);
    logic [W-1:0] mem_q [DEPTH];

    assign full_o  = (depth_o == DEP_W'(DEPTH));
    assign empty_o = (depth_o == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            depth_o <= '0;
        else if (push_i)
            depth_o <= depth_o + 1'b1;
        else if (pop_i)
            depth_o <= depth_o - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (push_i)
            mem_q[depth_o[DEP_W-2:0]] <= din_i;
    end

    always_comb begin
        top_o = '0;
        for (int i = 0; i < DEPTH; i++)
            if (DEP_W'(i + 1) == depth_o)
                top_o = mem_q[i];
    end

    // R10
    stack_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);
    // R7
    stack_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
    // R6
    stack_push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int NSRC     = 8,
    parameter int PRIO_W   = 4,
    parameter int VEC_W    = 9,
    parameter int DEPTH    = 16,
    parameter int SPUR_VEC = 511,
    localparam int IDX_W   = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int SEL_W   = $clog2(NSRC + 1),
    localparam int DEP_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   req_i,
    input  logic              cfg_we_i,
    input  logic [SEL_W-1:0]  cfg_sel_i,
    input  logic [PRIO_W-1:0] cfg_data_i,
    input  logic              ack_i,
    input  logic              eoi_i,
    output logic              irq_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic [PRIO_W-1:0] cur_prio_o,
    output logic [DEP_W-1:0]  nest_depth_o
);
    import irq_ctrl_pkg::*;

    localparam logic [VEC_W-1:0] SPUR = VEC_W'(SPUR_VEC);

    logic [NSRC-1:0][PRIO_W-1:0] prio_tab;
    logic                        any_elig;
    logic [IDX_W-1:0]            win_idx;
    logic [PRIO_W-1:0]           win_prio;
    logic [PRIO_W-1:0]           stk_top;
    logic                        stk_full, stk_empty;
    logic                        take, pop, ack_only, ceil_wr;
    irq_state_e                  state_q, state_d;

    irq_prio_regs #(.NSRC(NSRC), .PRIO_W(PRIO_W), .SEL_W(SEL_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .sel_i(cfg_sel_i),
        .data_i(cfg_data_i), .prio_o(prio_tab));

    irq_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) arb_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .prio_i(prio_tab),
        .ceil_i(cur_prio_o), .any_o(any_elig), .idx_o(win_idx), .prio_o(win_prio));

    assign ack_only = ack_i && !eoi_i;
    assign take     = ack_only && any_elig && !stk_full;
    assign pop      = eoi_i && !stk_empty;
    assign ceil_wr  = cfg_we_i && (cfg_sel_i == SEL_W'(NSRC));

    irq_prio_stack #(.DEPTH(DEPTH), .W(PRIO_W), .DEP_W(DEP_W)) stk_i (
        .clk(clk), .rst_n(rst_n), .push_i(take), .pop_i(pop),
        .din_i(cur_prio_o), .top_o(stk_top), .depth_o(nest_depth_o),
        .full_o(stk_full), .empty_o(stk_empty));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    // next state: T_RAISE, T_DROP, T_HOLD_Q, T_HOLD_S
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  state_d = any_elig ? ST_SIGNAL : ST_QUIET;
            ST_SIGNAL: state_d = any_elig ? ST_SIGNAL : ST_QUIET;
            default:   state_d = ST_QUIET;
        endcase
    end

    // outputs
    always_comb begin
        irq_o = (state_q == ST_SIGNAL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_prio_o <= '0;
            vec_o      <= SPUR;
        end else begin
            if (take)          cur_prio_o <= win_prio;
            else if (pop)      cur_prio_o <= stk_top;
            else if (ceil_wr)  cur_prio_o <= cfg_data_i;
            if (ack_only)      vec_o <= take ? VEC_W'(win_idx) : SPUR;
        end
    end

    // R5
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(any_elig));
    // R5
    irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> !$past(any_elig));
    // R6
    ack_raises_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (cur_prio_o == $past(win_prio)) && (nest_depth_o == $past(nest_depth_o) + 1'b1));
    // R4
    ack_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> vec_o == VEC_W'($past(win_idx)));
    // R8
    spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_only && !take && !cfg_we_i) |=>
            (vec_o == SPUR) && $stable(cur_prio_o) && $stable(nest_depth_o));
    // R7
    eoi_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> cur_prio_o == $past(stk_top));
    // R7
    eoi_empty_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && stk_empty && !cfg_we_i) |=> $stable(cur_prio_o) && $stable(nest_depth_o));
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
    localparam int NSRC = 8;
    localparam int SPUR = 511;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_sel = '0;
    logic [3:0] cfg_data = '0;
    logic       ack = 1'b0;
    logic       eoi = 1'b0;
    logic       irq;
    logic [8:0] vec;
    logic [3:0] cur;
    logic [4:0] depth;

    int checks = 0;
    int errors = 0;
    int prio_m [NSRC];
    logic [31:0] lfsr = 32'h1234_5678;

    always #5 clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .cfg_we_i(cfg_we),
        .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data), .ack_i(ack), .eoi_i(eoi),
        .irq_o(irq), .vec_o(vec), .cur_prio_o(cur), .nest_depth_o(depth));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input int sel, input int data);
        cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_data = 4'(data);
        if (sel < NSRC) prio_m[sel] = data;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic pulse_eoi();
        eoi = 1'b1; tick(); eoi = 1'b0;
    endtask

    function automatic logic [31:0] rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr;
    endfunction

    // model of R2/R3: highest priority above ceiling, lowest index on ties
    function automatic int model_win(input logic [7:0] r, input int ceil);
        int best = ceil;
        int idx = -1;
        for (int i = 0; i < NSRC; i++)
            if (r[i] && prio_m[i] > best) begin best = prio_m[i]; idx = i; end
        return idx;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; req = '0;
        for (int i = 0; i < NSRC; i++) prio_m[i] = 0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete actual=hang expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 cur", cur, 0);
        chk("R1 depth", depth, 0);
        chk("R1 vec", vec, SPUR);

        // R2 priority 0 never interrupts
        req = 8'hFF; tick(); tick();
        chk("R2 prio0 irq", irq, 0);
        pulse_ack();
        chk("R8 spurious vec", vec, SPUR);
        chk("R8 cur kept", cur, 0);
        chk("R8 depth kept", depth, 0);
        req = '0;

        // R5 latency of irq rise and fall
        wr(3, 5);
        req = 8'h08;
        chk("R5 irq before edge", irq, 0);
        tick();
        chk("R5 irq rise", irq, 1);
        req = 8'h00;
        chk("R5 irq still high", irq, 1);
        tick();
        chk("R5 irq fall", irq, 0);

        // R3 tie break and R4/R6/R7 nesting
        wr(1, 3); wr(2, 3); wr(5, 7);
        req = 8'h06; tick();
        pulse_ack();
        chk("R3 tie lowest idx", vec, 1);
        chk("R6 cur after ack", cur, 3);
        chk("R6 depth 1", depth, 1);
        tick();
        chk("R5 irq low at ceiling", irq, 0);
        req = 8'h26; tick(); tick();
        chk("R5 preempt irq", irq, 1);
        pulse_ack();
        chk("R4 vec nested", vec, 5);
        chk("R6 cur nested", cur, 7);
        chk("R6 depth 2", depth, 2);
        req = 8'h06;
        pulse_eoi();
        chk("R7 pop cur", cur, 3);
        chk("R7 pop depth", depth, 1);
        req = '0;
        pulse_eoi();
        chk("R7 pop to 0", cur, 0);
        pulse_eoi();
        chk("R7 empty eoi cur", cur, 0);
        chk("R7 empty eoi depth", depth, 0);
        // R7 ack and eoi together: only eoi acts
        req = 8'h08; tick();
        pulse_ack();
        chk("R7 setup depth", depth, 1);
        ack = 1'b1; eoi = 1'b1; tick(); ack = 1'b0; eoi = 1'b0;
        chk("R7 both pulses depth", depth, 0);
        chk("R7 both pulses cur", cur, 0);
        chk("R7 both pulses vec kept", vec, 3);
        req = '0;

        // R9 ceiling write masks equal priority
        wr(NSRC, 5);
        chk("R9 ceiling written", cur, 5);
        req = 8'h08; tick(); tick();
        chk("R9 equal masked", irq, 0);
        wr(3, 6); tick();
        chk("R9 above ceiling", irq, 1);
        req = '0;

        // R10 full stack gives spurious acknowledge
        do_reset();
        wr(2, 1);
        req = 8'h04;
        for (int k = 0; k < 16; k++) begin
            tick();
            pulse_ack();
            wr(NSRC, 0);
        end
        chk("R10 depth full", depth, 16);
        tick();
        pulse_ack();
        chk("R10 full spurious vec", vec, SPUR);
        chk("R10 full depth kept", depth, 16);
        chk("R10 full cur kept", cur, 0);
        req = '0;

        // sweep: R2 R3 R4 R5 R6 R7 R8 against the model
        do_reset();
        for (int t = 0; t < 400; t++) begin
            logic [7:0] r;
            int ceil, w;
            for (int i = 0; i < NSRC; i++) wr(i, int'(rnd() & 32'hF));
            ceil = int'(rnd() & 32'hF);
            wr(NSRC, ceil);
            r = rnd()[7:0];
            req = r;
            w = model_win(r, ceil);
            tick();
            chk("R5 sweep irq", irq, (w >= 0) ? 1 : 0);
            pulse_ack();
            if (w >= 0) begin
                chk("R4 sweep vec", vec, w);
                chk("R6 sweep cur", cur, prio_m[w]);
                chk("R6 sweep depth", depth, 1);
                tick();
                chk("R5 sweep irq after ack", irq, (model_win(r, prio_m[w]) >= 0) ? 1 : 0);
                pulse_eoi();
                chk("R7 sweep restore", cur, ceil);
                chk("R7 sweep depth", depth, 0);
            end else begin
                chk("R8 sweep vec", vec, SPUR);
                chk("R8 sweep cur", cur, ceil);
                chk("R8 sweep depth", depth, 0);
            end
            req = '0;
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule